// File: doc/BRIEF.md
# Select-Coded Register Transfer Bus

This block is the data path of a small accumulator machine: a 16-bit shared bus linking six working registers and a 4096-word by 16-bit memory. A 3-bit select code decides which single source drives the bus in a cycle. Every register has its own load, increment and clear control. Memory has a read strobe, which lets it drive the bus, and a write strobe. The memory address always comes from the address register.

Two registers, the address register and the program counter, are 12 bits wide. They go onto the bus with their upper four bits at zero, and when they load they take only the low 12 bits of the bus. The accumulator never loads from the bus. Its load control takes an ALU result supplied from outside the block. Because of this, a bus transfer into one register and an ALU load into the accumulator can finish in the same cycle. A one-cycle swap between the data register and the accumulator works this way.

The control sequencer and the ALU are outside this block. A sequencer drives the select and control lines one register transfer per clock.

Top module: `reg_bus_core`

## Requirements
- R1: The select code places one source on `bus_o`: 1 address register, 2 program counter, 3 data register, 4 accumulator, 5 instruction register, 6 temporary register. Code 7 places the memory word at the address-register location, but only while `mem_rd_i` is high. With code 7 and `mem_rd_i` low the bus is zero.
- R2: Select code 0 drives all zeros onto the bus.
- R3: The 12-bit address register and program counter appear on the bus with bits 15:12 at zero.
- R4: Control vectors use bit 0 address register, bit 1 program counter, bit 2 data register, bit 3 accumulator, bit 4 instruction register, bit 5 temporary register. A register other than the accumulator whose load bit is high takes the bus value at the rising edge. The 12-bit registers take bus bits 11:0.
- R5: The accumulator load takes `alu_res_i` and never the bus value.
- R6: For one register, clear has priority over load, and load has priority over increment. Increment wraps modulo the register width.
- R7: A register with no control bit asserted holds its value.
- R8: With `mem_wr_i` high, the word at the address held in the address register becomes the current bus value at the rising edge.
- R9: In one cycle, the data register can take the accumulator over the bus while the accumulator takes an ALU value equal to the old data register. The two values are exchanged.
- R10: An asynchronous active-low reset clears all six registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 3 | Bus source select code |
| ld_i | input | 6 | Per-register load controls |
| inr_i | input | 6 | Per-register increment controls |
| clr_i | input | 6 | Per-register clear controls |
| alu_res_i | input | 16 | ALU result for the accumulator load |
| mem_rd_i | input | 1 | Memory read strobe (memory drives bus at code 7) |
| mem_wr_i | input | 1 | Memory write strobe |
| bus_o | output | 16 | Shared bus value |
| ar_o | output | 12 | Address register |
| pc_o | output | 12 | Program counter |
| dr_o | output | 16 | Data register |
| ac_o | output | 16 | Accumulator |
| ir_o | output | 16 | Instruction register |
| tr_o | output | 16 | Temporary register |

## Verification
The assertions check on every cycle the per-register control behaviour:
- clear priority, load-from-bus capture, increment with wrap, and holding when idle;
- the accumulator taking only the ALU value;
- the zero upper bits of the narrow sources and of select code 0.

Only the bench scenarios can show the memory behaviour and the swap. The bench stores a pattern in every memory word and reads it back through the bus. It also checks the one-cycle exchange and each select code against a register model held in the bench.

// File: rtl/reg_bus_pkg.sv
package reg_bus_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned NUM_REGS = 6;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS + 2);
  localparam int unsigned MEM_CODE = NUM_REGS + 1;

  // register slot order; select code = slot + 1
  localparam int unsigned IDX_AR = 0;
  localparam int unsigned IDX_PC = 1;
  localparam int unsigned IDX_DR = 2;
  localparam int unsigned IDX_AC = 3;
  localparam int unsigned IDX_IR = 4;
  localparam int unsigned IDX_TR = 5;

  typedef struct packed {
    logic clr;
    logic ld;
    logic inr;
  } reg_ctl_t;

  function automatic int unsigned slot_width(int unsigned idx);
    return (idx == IDX_AR || idx == IDX_PC) ? ADDR_W : DATA_W;
  endfunction
endpackage

// File: rtl/bus_reg.sv
module bus_reg
  import reg_bus_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  reg_ctl_t     ctl_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (ctl_i.clr) q_o <= '0;
    else if (ctl_i.ld)  q_o <= d_i;
    else if (ctl_i.inr) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/bus_src_mux.sv
module bus_src_mux
  import reg_bus_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NS = NUM_REGS,
  parameter int unsigned SW = SEL_W
) (
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] src_i [NS],
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rd_i,
  output logic [DW-1:0] bus_o
);
  localparam logic [SW-1:0] MemSel = SW'(NS + 1);

  always_comb begin
    bus_o = '0;
    for (int i = 0; i < int'(NS); i++) begin
      if (sel_i == SW'(i + 1)) bus_o = src_i[i];
    end
    if (sel_i == MemSel && mem_rd_i) bus_o = mem_rdata_i;
  end
endmodule

// File: rtl/bus_mem.sv
module bus_mem #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned Depth = 1 << AW;

  logic [DW-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/reg_bus_core.sv
module reg_bus_core
  import reg_bus_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    bus_sel_i,
  input  logic [NUM_REGS-1:0] ld_i,
  input  logic [NUM_REGS-1:0] inr_i,
  input  logic [NUM_REGS-1:0] clr_i,
  input  logic [DATA_W-1:0]   alu_res_i,
  input  logic                mem_rd_i,
  input  logic                mem_wr_i,
  output logic [DATA_W-1:0]   bus_o,
  output logic [ADDR_W-1:0]   ar_o,
  output logic [ADDR_W-1:0]   pc_o,
  output logic [DATA_W-1:0]   dr_o,
  output logic [DATA_W-1:0]   ac_o,
  output logic [DATA_W-1:0]   ir_o,
  output logic [DATA_W-1:0]   tr_o
);
  logic [DATA_W-1:0] bus_w;
  logic [DATA_W-1:0] src_w [NUM_REGS];
  logic [DATA_W-1:0] mem_rdata_w;
  logic [ADDR_W-1:0] mem_addr_w;

  for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_slot
    localparam int unsigned W = slot_width(g);
    logic [W-1:0] d_w;
    logic [W-1:0] q_w;
    reg_ctl_t     ctl_w;

    assign ctl_w = '{clr: clr_i[g], ld: ld_i[g], inr: inr_i[g]};

    if (g == int'(IDX_AC)) begin : g_alu_src
      assign d_w = alu_res_i[W-1:0];
    end else begin : g_bus_src
      assign d_w = bus_w[W-1:0];
    end

    bus_reg #(.W(W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ctl_i (ctl_w),
      .d_i   (d_w),
      .q_o   (q_w)
    );

    // narrow sources zero-extended onto the bus
    assign src_w[g] = DATA_W'(q_w);
  end

  assign mem_addr_w = src_w[IDX_AR][ADDR_W-1:0];

  bus_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .clk_i  (clk_i),
    .addr_i (mem_addr_w),
    .wdata_i(bus_w),
    .we_i   (mem_wr_i),
    .rdata_o(mem_rdata_w)
  );

  bus_src_mux #(.DW(DATA_W), .NS(NUM_REGS), .SW(SEL_W)) u_mux (
    .sel_i      (bus_sel_i),
    .src_i      (src_w),
    .mem_rdata_i(mem_rdata_w),
    .mem_rd_i   (mem_rd_i),
    .bus_o      (bus_w)
  );

  assign bus_o = bus_w;
  assign ar_o  = mem_addr_w;
  assign pc_o  = src_w[IDX_PC][ADDR_W-1:0];
  assign dr_o  = src_w[IDX_DR];
  assign ac_o  = src_w[IDX_AC];
  assign ir_o  = src_w[IDX_IR];
  assign tr_o  = src_w[IDX_TR];
endmodule

// File: rtl/reg_bus_core_chk.sv
module reg_bus_core_chk
  import reg_bus_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [SEL_W-1:0]    bus_sel_i,
  input logic [NUM_REGS-1:0] ld_i,
  input logic [NUM_REGS-1:0] inr_i,
  input logic [NUM_REGS-1:0] clr_i,
  input logic [DATA_W-1:0]   alu_res_i,
  input logic                mem_rd_i,
  input logic                mem_wr_i,
  input logic [DATA_W-1:0]   bus_o,
  input logic [ADDR_W-1:0]   ar_o,
  input logic [ADDR_W-1:0]   pc_o,
  input logic [DATA_W-1:0]   dr_o,
  input logic [DATA_W-1:0]   ac_o,
  input logic [DATA_W-1:0]   ir_o,
  input logic [DATA_W-1:0]   tr_o
);
  // R2
  zero_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i == '0) |-> (bus_o == '0));

  // R3
  narrow_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i == SEL_W'(IDX_AR + 1) || bus_sel_i == SEL_W'(IDX_PC + 1))
      |-> (bus_o[DATA_W-1:ADDR_W] == '0));

  // R4
  dr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i[IDX_DR] && !clr_i[IDX_DR]) |=> (dr_o == $past(bus_o)));

  // R4
  ar_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i[IDX_AR] && !clr_i[IDX_AR]) |=> (ar_o == $past(bus_o[ADDR_W-1:0])));

  // R5
  ac_alu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i[IDX_AC] && !clr_i[IDX_AC]) |=> (ac_o == $past(alu_res_i)));

  // R6
  tr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i[IDX_TR] |=> (tr_o == '0));

  // R6
  pc_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inr_i[IDX_PC] && !ld_i[IDX_PC] && !clr_i[IDX_PC])
      |=> (pc_o == $past(pc_o) + 1'b1));

  // R7
  ir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inr_i[IDX_IR] && !ld_i[IDX_IR] && !clr_i[IDX_IR]) |=> $stable(ir_o));
endmodule

bind reg_bus_core reg_bus_core_chk u_chk (.*);

// File: tb/reg_bus_core_tb_top.sv
module reg_bus_core_tb_top;
  import reg_bus_pkg::*;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [SEL_W-1:0]    bus_sel_i = '0;
  logic [NUM_REGS-1:0] ld_i = '0, inr_i = '0, clr_i = '0;
  logic [DATA_W-1:0]   alu_res_i = '0;
  logic                mem_rd_i = 1'b0, mem_wr_i = 1'b0;
  logic [DATA_W-1:0]   bus_o;
  logic [ADDR_W-1:0]   ar_o, pc_o;
  logic [DATA_W-1:0]   dr_o, ac_o, ir_o, tr_o;

  reg_bus_core dut_i (.*);

  always #5 clk_i = ~clk_i;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] m_reg [NUM_REGS];
  logic [DATA_W-1:0] m_mem [1 << ADDR_W];

  function automatic logic [DATA_W-1:0] mask_w(int unsigned idx, logic [DATA_W-1:0] v);
    return (idx == IDX_AR || idx == IDX_PC) ? (v & 16'h0FFF) : v;
  endfunction

  function automatic logic [DATA_W-1:0] exp_bus(logic [SEL_W-1:0] sel, logic rd);
    if (sel == 3'd0) return '0;
    if (sel == 3'd7) return rd ? m_mem[m_reg[IDX_AR][ADDR_W-1:0]] : '0;
    return m_reg[sel - 1];
  endfunction

  function automatic logic [DATA_W-1:0] pat(int unsigned a);
    return 16'(a * 40503) ^ 16'h5A5A;
  endfunction

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    chk(tag, DATA_W'(ar_o), m_reg[IDX_AR], "ar");
    chk(tag, DATA_W'(pc_o), m_reg[IDX_PC], "pc");
    chk(tag, dr_o, m_reg[IDX_DR], "dr");
    chk(tag, ac_o, m_reg[IDX_AC], "ac");
    chk(tag, ir_o, m_reg[IDX_IR], "ir");
    chk(tag, tr_o, m_reg[IDX_TR], "tr");
  endtask

  // called just after a falling edge; checks bus, clocks once, checks registers
  task automatic step(string tag, logic [SEL_W-1:0] sel, logic [5:0] ld, logic [5:0] inr,
                      logic [5:0] clr, logic [DATA_W-1:0] alu, logic rd, logic wr);
    logic [DATA_W-1:0] b;
    logic [DATA_W-1:0] nxt [NUM_REGS];
    bus_sel_i = sel; ld_i = ld; inr_i = inr; clr_i = clr;
    alu_res_i = alu; mem_rd_i = rd; mem_wr_i = wr;
    #1;
    b = exp_bus(sel, rd);
    chk(tag, bus_o, b, "bus");
    for (int i = 0; i < int'(NUM_REGS); i++) begin
      if (clr[i])      nxt[i] = '0;
      else if (ld[i])  nxt[i] = mask_w(i, (i == int'(IDX_AC)) ? alu : b);
      else if (inr[i]) nxt[i] = mask_w(i, m_reg[i] + 16'd1);
      else             nxt[i] = m_reg[i];
    end
    if (wr) m_mem[m_reg[IDX_AR][ADDR_W-1:0]] = b;
    for (int i = 0; i < int'(NUM_REGS); i++) m_reg[i] = nxt[i];
    @(negedge clk_i);
    chk_regs(tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d0, a0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < int'(NUM_REGS); i++) m_reg[i] = '0;
    #23;
    @(negedge clk_i);
    chk_regs("R10");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: select zero
    step("R2", 3'd0, 6'h00, 6'h00, 6'h00, 16'hBEEF, 1'b1, 1'b0);
    // R5: accumulator takes ALU while bus carries something else
    step("R5", 3'd0, 6'h08, 6'h00, 6'h00, 16'hF123, 1'b0, 1'b0);
    // R4: AR takes low 12 bits of bus from AC; TR and IR too
    step("R4", 3'd4, 6'h31, 6'h00, 6'h00, 16'h0000, 1'b0, 1'b0);
    // R3: narrow AR on bus
    step("R3", 3'd1, 6'h04, 6'h00, 6'h00, 16'h0000, 1'b0, 1'b0);
    // R6: clear beats load and increment; load beats increment
    step("R6", 3'd4, 6'h30, 6'h30, 6'h20, 16'h0000, 1'b0, 1'b0);
    // R6: PC wrap
    step("R6", 3'd4, 6'h02, 6'h00, 6'h00, 16'h0000, 1'b0, 1'b0);
    step("R6", 3'd0, 6'h00, 6'h02, 6'h00, 16'h0000, 1'b0, 1'b0);
    chk("R6", DATA_W'(pc_o), 16'h0124, "pc after inc");
    step("R6", 3'd0, 6'h08, 6'h00, 6'h00, 16'h0FFF, 1'b0, 1'b0);
    step("R6", 3'd4, 6'h02, 6'h00, 6'h00, 16'h0000, 1'b0, 1'b0);
    step("R6", 3'd0, 6'h00, 6'h02, 6'h00, 16'h0000, 1'b0, 1'b0);
    chk("R6", DATA_W'(pc_o), 16'h0000, "pc wrap");
    // R7: idle holds
    step("R7", 3'd2, 6'h00, 6'h00, 6'h00, 16'h1234, 1'b1, 1'b1);
    // R9: swap DR and AC in one cycle
    step("R9", 3'd0, 6'h08, 6'h00, 6'h00, 16'hA5C3, 1'b0, 1'b0);
    step("R9", 3'd4, 6'h04, 6'h00, 6'h00, 16'h0000, 1'b0, 1'b0);
    step("R9", 3'd0, 6'h08, 6'h00, 6'h00, 16'h1E2D, 1'b0, 1'b0);
    d0 = dr_o; a0 = ac_o;
    step("R9", 3'd4, 6'h0C, 6'h00, 6'h00, d0, 1'b0, 1'b0);
    chk("R9", dr_o, a0, "dr after swap");
    chk("R9", ac_o, d0, "ac after swap");

    // R8: fill every memory word through the bus, AR auto-increment
    step("R8", 3'd0, 6'h00, 6'h00, 6'h01, 16'h0000, 1'b0, 1'b0);
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      step("R8", 3'd0, 6'h08, 6'h00, 6'h00, pat(a), 1'b0, 1'b0);
      step("R8", 3'd4, 6'h00, 6'h01, 6'h00, 16'h0000, 1'b0, 1'b1);
    end
    // R8: read back a few words into DR
    for (int k = 0; k < 16; k++) begin
      int unsigned a = $urandom_range(0, (1 << ADDR_W) - 1);
      step("R8", 3'd0, 6'h08, 6'h00, 6'h00, 16'(a), 1'b0, 1'b0);
      step("R8", 3'd4, 6'h01, 6'h00, 6'h00, 16'h0000, 1'b0, 1'b0);
      step("R8", 3'd7, 6'h04, 6'h00, 6'h00, 16'h0000, 1'b1, 1'b0);
      chk("R8", dr_o, pat(a), "readback");
    end
    // R1: memory select with read strobe low
    step("R1", 3'd7, 6'h10, 6'h00, 6'h00, 16'h0000, 1'b0, 1'b0);

    // R1/R4/R6/R7/R8: constrained random transfers
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] ld, inr, clr;
      ld  = 6'($urandom) & 6'($urandom);
      inr = 6'($urandom) & 6'($urandom);
      clr = 6'($urandom) & 6'($urandom) & 6'($urandom);
      step("R1", 3'($urandom), ld, inr, clr, 16'($urandom),
           1'($urandom), ($urandom_range(0, 7) == 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule